// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is an SPI slave that lives inside the logic fabric. It takes fixed 16-bit command words from a host controller and sends each word to one of two internal registers. The serial clock, chip select and MOSI pins are synchronised into the system clock, and every word is shifted in on rising serial-clock edges. When chip select is released, the word is checked and then decoded. The upper four bits select the command and the lower twelve bits carry its payload.

One command loads the payload into a 12-bit configuration word, which downstream logic reads as its operating mode. A second command sets or clears a trace-enable flag. A word is acted on only when exactly sixteen clock edges occurred inside its chip-select window. Short or long frames, and words with an unassigned command, leave both registers unchanged.

The framer is a four-state machine:
- `S_IDLE` waits for chip select to fall and then goes to `S_SHIFT`.
- `S_SHIFT` counts bits. When chip select rises with a full count it goes to `S_COMMIT`. When chip select rises early it goes back to `S_IDLE`. A seventeenth edge sends it to `S_DROP`.
- `S_DROP` waits for chip select to rise and then returns to `S_IDLE`.
- `S_COMMIT` lasts one cycle and hands the word to the dispatcher before returning to `S_IDLE`.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset `conf_word` is 0 (the off mode) and `trace_en` is 0.
- R2: A complete word with command code 1 (bits 15:12 = 4'h1) loads bits 11:0 into `conf_word` and leaves `trace_en` unchanged.
- R3: A complete word with command code 2 (bits 15:12 = 4'h2) sets `trace_en` to bit 0 of the word (1 enables, 0 disables) and leaves `conf_word` unchanged.
- R4: Bits are captured on rising `spi_sck` edges, most significant bit first, so the first bit sent is bit 15.
- R5: A frame with fewer than 16 clock edges before chip select rises is discarded.
- R6: A frame with more than 16 clock edges before chip select rises is discarded.
- R7: Command codes other than 1 and 2 change neither output.
- R8: The outputs do not change until chip select rises, even after all 16 bits have been shifted in.
- R9: Each word needs its own chip-select window, and consecutive framed words are each applied in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low chip select, one window per word |
| spi_mosi | input | 1 | Serial data from the host |
| conf_word | output | 12 | Configuration / mode register |
| trace_en | output | 1 | Trace-enable flag |

## Verification
All sixteen command codes are swept, each with four payloads: all zeros, all ones, an alternating pattern, and a value derived from the code. This separates the configuration command from the trace command and from the unassigned codes, and the asymmetric payloads expose any bit reversal or field shift. Frames of 15 and 17 edges check the exact-count rule. A check taken after the sixteenth bit but before chip select rises shows that nothing commits early. Back-to-back words with alternating trace values confirm that each window is handled on its own.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SHIFT  = 2'd1,
        S_DROP   = 2'd2,
        S_COMMIT = 2'd3
    } rx_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_sync
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_pin
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
                else        chain <= {chain[STAGES-2:0], pin_in[g]};
            end
            assign pin_sync[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi_word_framer.sv
module spi_word_framer
    import spi_cmd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    rx_state_t         state, next_state;
    logic              sck_q;
    logic              sck_rise;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] shreg;

    assign sck_rise = sck_s & ~sck_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE:   if (!cs_n_s) next_state = S_SHIFT;
            S_SHIFT: begin
                if (cs_n_s)                       next_state = (cnt == FULL) ? S_COMMIT : S_IDLE;
                else if (sck_rise && cnt == FULL) next_state = S_DROP;
            end
            S_DROP:   if (cs_n_s) next_state = S_IDLE;
            S_COMMIT: next_state = S_IDLE;
        endcase
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            sck_q <= sck_s;
            if (state == S_IDLE) begin
                cnt <= '0;
            end else if (state == S_SHIFT && !cs_n_s && sck_rise && cnt != FULL) begin
                shreg <= {shreg[WORD_W-2:0], mosi_s};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        word_valid = (state == S_COMMIT);
        word       = shreg;
    end

    p_commit_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT) |-> (cnt == FULL));
    p_drop_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP) |=> (state != S_COMMIT));
    p_commit_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    p_commit_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> cs_n_s);
endmodule

// File: rtl/spi_cmd_dispatch.sv
module spi_cmd_dispatch #(
    parameter int              OP_W     = 4,
    parameter int              DATA_W   = 12,
    parameter logic [OP_W-1:0] OP_CONF  = 4'h1,
    parameter logic [OP_W-1:0] OP_TRACE = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] payload,
    output logic [DATA_W-1:0] conf_word,
    output logic              trace_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conf_word <= '0;
            trace_en  <= 1'b0;
        end else if (word_valid) begin
            if (opcode == OP_CONF)  conf_word <= payload;
            if (opcode == OP_TRACE) trace_en  <= payload[0];
        end
    end

    p_conf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(conf_word) && $stable(trace_en));
    p_conf_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && opcode == OP_CONF) |=> (conf_word == $past(payload)) && $stable(trace_en));
    p_trace_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && opcode == OP_TRACE) |=> (trace_en == $past(payload[0])) && $stable(conf_word));
    p_unknown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && opcode != OP_CONF && opcode != OP_TRACE) |=> $stable(conf_word) && $stable(trace_en));
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
    parameter int OP_W        = 4,
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int OP_CONF     = 1,
    parameter int OP_TRACE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic [DATA_W-1:0] conf_word,
    output logic              trace_en
);
    localparam int WORD_W = OP_W + DATA_W;

    logic [2:0]        pins_s;
    logic              word_valid;
    logic [WORD_W-1:0] word;

    spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({spi_mosi, spi_cs_n, spi_sck}),
        .pin_sync (pins_s)
    );

    spi_word_framer #(.WORD_W(WORD_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (pins_s[0]),
        .cs_n_s     (pins_s[1]),
        .mosi_s     (pins_s[2]),
        .word_valid (word_valid),
        .word       (word)
    );

    spi_cmd_dispatch #(
        .OP_W     (OP_W),
        .DATA_W   (DATA_W),
        .OP_CONF  (OP_W'(OP_CONF)),
        .OP_TRACE (OP_W'(OP_TRACE))
    ) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .opcode     (word[WORD_W-1 -: OP_W]),
        .payload    (word[DATA_W-1:0]),
        .conf_word  (conf_word),
        .trace_en   (trace_en)
    );
endmodule

// File: tb/sim_spi_cmd_rx.sv
module sim_spi_cmd_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic [11:0] conf_word;
    logic        trace_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [11:0] exp_conf = '0;
    logic        exp_tr   = 1'b0;

    always #2 clk = ~clk;

    spi_cmd_rx u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .conf_word(conf_word), .trace_en(trace_en)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [11:0] got_c, input logic got_t);
        n_tests++;
        if (got_c !== exp_conf || got_t !== exp_tr) begin
            n_fail++;
            $display("FAIL %s: actual conf=%h trace=%b, expected conf=%h trace=%b",
                     req, got_c, got_t, exp_conf, exp_tr);
        end
    endtask

    // Sends nbits edges; bit i (i<16) is w[15-i] (MSB first), extras are 0.
    task automatic send(input logic [15:0] w, input int nbits, input bit peek, input string req);
        spi_cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(4);
            spi_sck = 1'b1;
            wait_clk(4);
            spi_sck = 1'b0;
        end
        wait_clk(6);
        if (peek) chk({req, " R8 before cs rise"}, conf_word, trace_en);
        spi_cs_n = 1'b1;
        wait_clk(8);
        if (nbits == 16) begin
            if (w[15:12] == 4'h1) exp_conf = w[11:0];
            if (w[15:12] == 4'h2) exp_tr   = w[0];
        end
        chk(req, conf_word, trace_en);
    endtask

    initial begin
        wait_clk(3);
        chk("R1 reset", conf_word, trace_en);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1 after reset release", conf_word, trace_en);

        // Exhaustive opcode sweep, several payloads each (R2, R3, R4, R7)
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 4; k++) begin
                logic [11:0] pl;
                case (k)
                    0: pl = 12'h000;
                    1: pl = 12'hFFF;
                    2: pl = 12'hA5C;
                    default: pl = 12'(op * 12'h111) ^ 12'h3C3;
                endcase
                send({4'(op), pl}, 16, 1'b0,
                     (op == 1) ? "R2 R4 conf write" :
                     (op == 2) ? "R3 R4 trace write" : "R7 unknown opcode");
            end
        end

        send(16'h1123, 16, 1'b0, "R2 set known conf");
        send(16'h1ABC, 15, 1'b0, "R5 short frame discarded");
        send(16'h2001, 15, 1'b0, "R5 short trace frame discarded");
        send(16'h1ABC, 17, 1'b0, "R6 long frame discarded");
        send(16'h2001, 17, 1'b0, "R6 long trace frame discarded");
        send(16'h1801, 16, 1'b1, "R8 commit on cs rise");
        send(16'h2001, 16, 1'b0, "R9 trace on");
        send(16'h2000, 16, 1'b0, "R9 trace off");
        send(16'h2001, 16, 1'b0, "R9 trace on again");
        send(16'h1001, 16, 1'b0, "R4 lsb only");
        send(16'h1800, 16, 1'b0, "R4 msb only");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule